// File: doc/BRIEF.md
# Write-Only I2C Configuration Register Target

This block is a write-only I2C target that takes control bytes for an audio processor and keeps them in a bank of eight-bit configuration registers. The system clock samples SCL and SDA through a two-flop synchronizer. Bus events are detected on the synchronized samples. The block answers only to one fixed chip address. The register contents are driven out in parallel, so the analog side can use them directly.

A write transfer has four parts: a START, the chip address byte, a subaddress byte and any number of data bytes. The transfer ends with a STOP or a repeated START. In the subaddress, bits 3..0 choose the target register and bit 7 turns on pointer stepping. The target pulls SDA low in the ninth clock of every byte it accepts. After each register that is actually stored, it pulses a one-cycle strobe that carries the register index.

The control state machine has five states:

- ST_IDLE waits for a START.
- ST_ADDR collects the address byte. A match moves it to ST_SUB. A mismatch moves it to ST_SKIP.
- ST_SUB collects the subaddress byte and then moves to ST_DATA.
- ST_DATA collects data bytes until the transfer ends.
- ST_SKIP ignores the bus.

From any state, a START leads to ST_ADDR and a STOP leads to ST_IDLE.

Top module: `ctrl_i2c_regbank`

## Requirements
- R1: After reset the register slots hold these values: 0 = 0x3F (maximum input attenuation), 1 = 0x3F (surround off, fixed output, maximum effect attenuation), 2 = 0x00, 3 = 0x07, 4 = 0x0F, 5 = 0x7F and 6 = 0x7F (both speakers muted), 9 = 0x03 (first input selected). The SDA pull-down is released after reset. Register i appears on regs_o[8*i+7:8*i].
- R2: A STOP or a START at any point returns the block to the start of a transfer. A byte that was only partly received is discarded, and registers already written keep their values.
- R3: The address byte 0x80 is acknowledged. Any other address byte, including 0x81, is not acknowledged. After a non-matching address, no later byte is acknowledged or stored until the next START.
- R4: The subaddress byte is always acknowledged. Its bits 3..0 select the register, bit 7 enables pointer stepping, and bits 6..4 have no effect.
- R5: With stepping off, every data byte up to the end of the transfer is written to the selected register, so the last byte remains.
- R6: With stepping on, each data byte goes to the pointer value and the pointer then increments, wrapping from 15 to 0. Data bytes that land on 10 to 15 are acknowledged but not stored.
- R7: Data bytes aimed at subaddresses 7 and 8 are acknowledged and not stored. Slots 7 and 8 always read 0.
- R8: Each stored byte gives exactly one one-cycle wr_stb_o pulse, and wr_idx_o carries the register index. Register outputs change only in a strobe cycle.
- R9: sda_pull_n_o is low only in the acknowledge clock of an accepted byte. It changes only while SCL is low and is released after the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_pull_n_o | output | 1 | Active-low open-drain enable: 0 pulls SDA low |
| regs_o | output | 80 | Parallel register contents, slot i at bits 8*i+7..8*i |
| wr_stb_o | output | 1 | One-cycle pulse after a register is stored |
| wr_idx_o | output | 4 | Index of the register just stored |

## Verification
The hardest situations to reach are transfers cut short at odd points. These are a STOP after only a few bits of a data byte, a repeated START inside the subaddress phase, and a stepping pointer that crosses the reserved slots, the unused range 10 to 15 and the wrap to 0 within one transfer. The bench reaches each one by driving a bit-level bus master with explicit partial-byte and repeated-START tasks. It starts stepping transfers at subaddresses 5 and 14 so that a short burst crosses every boundary. A behavioural model tracks the expected registers and strobe indices in queues. The model is compared with the outputs on every idle clock and after each transfer.

// File: rtl/ctrl_i2c_pkg.sv
package ctrl_i2c_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 10;
    localparam int PTR_W    = 4;
    localparam logic [7:0] CHIP_ADDR = 8'h80;
    // Slots that accept no data (subaddresses 7 and 8)
    localparam logic [NUM_REGS-1:0] RSVD_MASK = 10'b01_1000_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_DATA,
        ST_SKIP
    } tgt_state_e;

    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h3F;
            1:       return 8'h3F;
            3:       return 8'h07;
            4:       return 8'h0F;
            5:       return 8'h7F;
            6:       return 8'h7F;
            9:       return 8'h03;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic scl_prev, sda_prev;
    logic scl_s, sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q    <= '1;
            sda_q    <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_q    <= {scl_q[STAGES-2:0], scl_i};
            sda_q    <= {sda_q[STAGES-2:0], sda_i};
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_s      = scl_q[STAGES-1];
    assign sda_s      = sda_q[STAGES-1];
    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s & ~scl_prev;
    assign scl_fall_o = ~scl_s & scl_prev;
    // SDA edges while SCL stays high are bus conditions
    assign start_o    = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_o     = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import ctrl_i2c_pkg::*;
#(
    parameter logic [7:0] ADDR = 8'h80,
    parameter int PW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise_i,
    input  logic          scl_fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          sda_bit_i,
    output logic          sda_pull_n_o,
    output logic          wr_req_o,
    output logic [PW-1:0] wr_ptr_o,
    output logic [DW-1:0] wr_data_o
);
    tgt_state_e state, nxt;
    logic [3:0]    bit_cnt;
    logic [DW-1:0] shreg;
    logic          byte_full, in_ack, auto_inc;
    logic [PW-1:0] ptr;
    logic          receiving, byte_end, addr_hit;

    assign receiving = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
    assign byte_end  = scl_fall_i && byte_full;
    assign addr_hit  = (shreg == ADDR);

    always_comb begin
        nxt = state;
        if (start_i)
            nxt = ST_ADDR;
        else if (stop_i)
            nxt = ST_IDLE;
        else if (byte_end) begin
            unique case (state)
                ST_ADDR: nxt = addr_hit ? ST_SUB : ST_SKIP;
                ST_SUB:  nxt = ST_DATA;
                ST_IDLE, ST_DATA, ST_SKIP: nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt      <= '0;
            shreg        <= '0;
            byte_full    <= 1'b0;
            in_ack       <= 1'b0;
            auto_inc     <= 1'b0;
            ptr          <= '0;
            sda_pull_n_o <= 1'b1;
            wr_req_o     <= 1'b0;
            wr_ptr_o     <= '0;
            wr_data_o    <= '0;
        end else begin
            wr_req_o <= 1'b0;
            if (start_i || stop_i) begin
                bit_cnt      <= '0;
                byte_full    <= 1'b0;
                in_ack       <= 1'b0;
                sda_pull_n_o <= 1'b1;
            end else if (receiving) begin
                if (scl_rise_i && !byte_full && !in_ack) begin
                    shreg <= {shreg[DW-2:0], sda_bit_i};
                    if (bit_cnt == 4'(DW - 1)) begin
                        byte_full <= 1'b1;
                        bit_cnt   <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end
                if (scl_fall_i) begin
                    if (byte_full) begin
                        byte_full    <= 1'b0;
                        in_ack       <= 1'b1;
                        sda_pull_n_o <= (state == ST_ADDR) ? !addr_hit : 1'b0;
                        if (state == ST_SUB) begin
                            ptr      <= shreg[PW-1:0];
                            auto_inc <= shreg[DW-1];
                        end
                        if (state == ST_DATA) begin
                            wr_req_o  <= 1'b1;
                            wr_ptr_o  <= ptr;
                            wr_data_o <= shreg;
                            if (auto_inc) ptr <= ptr + 1'b1;
                        end
                    end else if (in_ack) begin
                        in_ack       <= 1'b0;
                        sda_pull_n_o <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import ctrl_i2c_pkg::*;
#(
    parameter int NR = 10,
    parameter int DW = 8,
    parameter int PW = 4,
    parameter logic [NR-1:0] RSVD = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req_i,
    input  logic [PW-1:0]    wr_ptr_i,
    input  logic [DW-1:0]    wr_data_i,
    output logic [NR*DW-1:0] regs_o,
    output logic             wr_stb_o,
    output logic [PW-1:0]    wr_idx_o
);
    logic [NR-1:0] hit_v;

    for (genvar g = 0; g < NR; g++) begin : g_slot
        if (RSVD[g]) begin : g_rsvd
            assign hit_v[g] = 1'b0;
            assign regs_o[g*DW +: DW] = '0;
        end else begin : g_reg
            logic [DW-1:0] val;
            assign hit_v[g] = (wr_ptr_i == PW'(g));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    val <= DW'(reg_default(g));
                else if (wr_req_i && hit_v[g])
                    val <= wr_data_i;
            end
            assign regs_o[g*DW +: DW] = val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb_o <= 1'b0;
            wr_idx_o <= '0;
        end else begin
            wr_stb_o <= wr_req_i && (|hit_v);
            if (wr_req_i && (|hit_v)) wr_idx_o <= wr_ptr_i;
        end
    end
endmodule

// File: rtl/ctrl_i2c_regbank.sv
module ctrl_i2c_regbank
    import ctrl_i2c_pkg::*;
#(
    parameter logic [7:0] ADDR = CHIP_ADDR,
    parameter int SYNC_STAGES  = 2,
    parameter int NR           = NUM_REGS,
    parameter int DW           = REG_W,
    parameter int PW           = PTR_W,
    parameter logic [NR-1:0] RSVD = RSVD_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_n_o,
    output logic [NR*DW-1:0] regs_o,
    output logic             wr_stb_o,
    output logic [PW-1:0]    wr_idx_o
);
    logic sda_bit, scl_rise, scl_fall, start_ev, stop_ev;
    logic          wr_req;
    logic [PW-1:0] wr_ptr;
    logic [DW-1:0] wr_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_bit), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_ev), .stop_o(stop_ev)
    );

    i2c_target_fsm #(.ADDR(ADDR), .PW(PW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_ev), .stop_i(stop_ev), .sda_bit_i(sda_bit),
        .sda_pull_n_o(sda_pull_n_o), .wr_req_o(wr_req),
        .wr_ptr_o(wr_ptr), .wr_data_o(wr_data)
    );

    cfg_reg_bank #(.NR(NR), .DW(DW), .PW(PW), .RSVD(RSVD)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_req_i(wr_req), .wr_ptr_i(wr_ptr),
        .wr_data_i(wr_data), .regs_o(regs_o), .wr_stb_o(wr_stb_o),
        .wr_idx_o(wr_idx_o)
    );
endmodule

// File: rtl/ctrl_i2c_regbank_chk.sv
module ctrl_i2c_regbank_chk #(
    parameter int NR = 10,
    parameter int DW = 8,
    parameter int PW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_pull_n_o,
    input logic [NR*DW-1:0] regs_o,
    input logic             wr_stb_o,
    input logic [PW-1:0]    wr_idx_o
);
    p_no_reserved_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (int'(wr_idx_o) < NR && wr_idx_o != PW'(7) && wr_idx_o != PW'(8)))
        else $error("reserved or unused slot strobed");

    p_regs_change_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> wr_stb_o)
        else $error("register changed without strobe");

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o)
        else $error("strobe longer than one cycle");

    p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_n_o) |-> !scl_i)
        else $error("SDA pull changed while SCL high");
endmodule

bind ctrl_i2c_regbank ctrl_i2c_regbank_chk #(.NR(NR), .DW(DW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_n_o(sda_pull_n_o),
    .regs_o(regs_o), .wr_stb_o(wr_stb_o), .wr_idx_o(wr_idx_o)
);

// File: tb/ctrl_i2c_regbank_bench.sv
`timescale 1ns/1ps
module ctrl_i2c_regbank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_n;
    logic [79:0] regs;
    logic wr_stb;
    logic [3:0] wr_idx;
    logic sda_line;

    assign sda_line = sda_m & sda_pull_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctrl_i2c_regbank u_ctrl_i2c_regbank (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_n_o(sda_pull_n), .regs_o(regs),
        .wr_stb_o(wr_stb), .wr_idx_o(wr_idx)
    );

    int tests = 0;
    int fails = 0;
    bit quiet = 1'b0;
    bit mm_seen = 1'b0;
    bit done = 1'b0;
    logic [7:0] exp_regs [10];
    int exp_idx_q[$];
    int act_idx_q[$];
    logic [7:0] tx [16];

    function automatic logic [79:0] exp_vec();
        logic [79:0] v = '0;
        for (int i = 0; i < 10; i++)
            if (i != 7 && i != 8) v[i*8 +: 8] = exp_regs[i];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: strobe capture and per-clock comparison while the bus is idle
    always @(negedge clk) begin
        if (rst_n && wr_stb) act_idx_q.push_back(int'(wr_idx));
        if (rst_n && quiet && !mm_seen && regs !== exp_vec()) begin
            mm_seen = 1'b1;
            tests++;
            fails++;
            $display("FAIL R8 idle compare: actual %h expected %h", regs, exp_vec());
        end
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl = 1'b1;   wait_q();
        sda_m = 1'b0; wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl = 1'b1;   wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_q();
        scl = 1'b1; wait_q(); wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_q();
        scl = 1'b1; wait_q();
        ack = ~sda_line;
        wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic master_write(input logic [7:0] addr, input logic [7:0] sub,
                                input int n, input bit do_stop);
        logic ack;
        int ptr;
        bit inc;
        bit hit;
        quiet = 1'b0;
        bus_start();
        send_byte(addr, ack);
        hit = (addr == 8'h80);
        chk("R3 address acknowledge", 80'(ack), 80'(hit));
        send_byte(sub, ack);
        chk(hit ? "R4 subaddress acknowledge" : "R3 ignored after miss", 80'(ack), 80'(hit));
        ptr = int'(sub[3:0]);
        inc = sub[7];
        for (int i = 0; i < n; i++) begin
            send_byte(tx[i], ack);
            chk(inc ? "R6 data acknowledge" : "R5 data acknowledge", 80'(ack), 80'(hit));
            if (hit && ptr < 10 && ptr != 7 && ptr != 8) begin
                exp_regs[ptr] = tx[i];
                exp_idx_q.push_back(ptr);
            end
            if (hit && inc) ptr = (ptr + 1) % 16;
        end
        if (do_stop) bus_stop();
    endtask

    task automatic settle_check(input string tag);
        logic [79:0] a, e;
        repeat (8) @(negedge clk);
        chk({tag, " registers"}, regs, exp_vec());
        a = '0; e = '0;
        a[79:64] = 16'(act_idx_q.size());
        e[79:64] = 16'(exp_idx_q.size());
        for (int i = 0; i < act_idx_q.size() && i < 8; i++) a[i*4 +: 4] = 4'(act_idx_q[i]);
        for (int i = 0; i < exp_idx_q.size() && i < 8; i++) e[i*4 +: 4] = 4'(exp_idx_q[i]);
        chk("R8 strobe indices", a, e);
        chk("R9 pull released", 80'(sda_pull_n), 80'(1));
        act_idx_q.delete();
        exp_idx_q.delete();
        mm_seen = 1'b0;
        quiet = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        exp_regs[0] = 8'h3F; exp_regs[1] = 8'h3F; exp_regs[2] = 8'h00;
        exp_regs[3] = 8'h07; exp_regs[4] = 8'h0F; exp_regs[5] = 8'h7F;
        exp_regs[6] = 8'h7F; exp_regs[7] = 8'h00; exp_regs[8] = 8'h00;
        exp_regs[9] = 8'h03;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 reset defaults", regs, exp_vec());
        chk("R1 pull released at reset", 80'(sda_pull_n), 80'(1));
        quiet = 1'b1;

        // R5: no stepping, three bytes into bass slot
        tx[0] = 8'hA1; tx[1] = 8'hB2; tx[2] = 8'hC3;
        master_write(8'h80, 8'h03, 3, 1'b1);
        settle_check("R5 repeat write");

        // R4: don't-care bits 6..4 set
        tx[0] = 8'h5A;
        master_write(8'h80, 8'h74, 1, 1'b1);
        settle_check("R4 don't-care bits");

        // R6/R7: stepping across reserved and unused slots
        tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33; tx[3] = 8'h44;
        tx[4] = 8'h55; tx[5] = 8'h66;
        master_write(8'h80, 8'h85, 6, 1'b1);
        settle_check("R7 stepping through reserved");

        // R6: wrap from 15 to 0
        tx[0] = 8'h01; tx[1] = 8'h02; tx[2] = 8'h9C; tx[3] = 8'h4D;
        master_write(8'h80, 8'h8E, 4, 1'b1);
        settle_check("R6 pointer wrap");

        // R7: direct write to reserved slot 8
        tx[0] = 8'hEE;
        master_write(8'h80, 8'h08, 1, 1'b1);
        settle_check("R7 reserved direct");

        // R3: wrong address and read address ignored
        tx[0] = 8'h00; tx[1] = 8'h00;
        master_write(8'h82, 8'h00, 2, 1'b1);
        settle_check("R3 wrong address");
        master_write(8'h81, 8'h82, 2, 1'b1);
        settle_check("R3 read address");

        // R2: partial data byte then STOP
        begin
            logic ack;
            quiet = 1'b0;
            bus_start();
            send_byte(8'h80, ack);
            chk("R2 address acknowledge", 80'(ack), 80'(1));
            send_byte(8'h00, ack);
            chk("R2 subaddress acknowledge", 80'(ack), 80'(1));
            for (int i = 0; i < 5; i++) send_bit(1'b0);
            bus_stop();
        end
        settle_check("R2 partial byte dropped");

        // R2: repeated START inside the subaddress byte
        begin
            logic ack;
            quiet = 1'b0;
            bus_start();
            send_byte(8'h80, ack);
            chk("R2 address acknowledge", 80'(ack), 80'(1));
            send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        end
        tx[0] = 8'h77;
        master_write(8'h80, 8'h02, 1, 1'b1);
        settle_check("R2 repeated start mid-subaddress");

        // R2: repeated START after complete write, then second write
        tx[0] = 8'h3C;
        master_write(8'h80, 8'h09, 1, 1'b0);
        tx[0] = 8'h00; tx[1] = 8'h12;
        master_write(8'h80, 8'h85, 2, 1'b1);
        settle_check("R2 repeated start between writes");

        // R5: subaddress only, no data
        master_write(8'h80, 8'h01, 0, 1'b1);
        settle_check("R5 no data bytes");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule